// File: doc/BRIEF.md
# Compare-and-Branch Fusion Detector

This block looks at a window of predecoded instruction descriptors held in an instruction queue and marks the pairs that the decoders may handle as a single macro-operation. Entry 0 is the oldest. A pair qualifies only when it has two parts. The first is a TEST or CMP whose operands use at most one immediate or memory source. The second is the next entry, a conditional jump whose condition reads only the carry flag, only the zero flag, or both. The detector never fuses anything while the machine runs in 64-bit mode. Each fused pair takes one decode slot, and the block reports the resulting number of macro-operations in the window.

When the newest valid entry could start a pair but its jump has not arrived yet, the block raises a hold so that downstream logic keeps that entry back for a while. The hold comes from a small state machine with three states:
- `ST_SCAN`: no pending head.
- `ST_WAIT`: a pending head is being timed.
- `ST_RELEASE`: the wait has expired and the head may issue unfused.

The transitions are:
- scan-to-wait, when a candidate tail appears.
- wait-to-scan, when the candidate goes away (for example because its jump arrived).
- wait-to-release, when the timer reaches its limit.
- release-to-scan, when the candidate goes away.

The per-entry decode and the pair scan are combinational. Only the wait timer holds state.

Top module: `cmpbr_fuse`

## Requirements
- R1: Entry i is fused only if its class field is TEST (2'd1) or CMP (2'd2) and entry i+1 has class JCC (2'd3). Class 2'd0 is any other instruction.
- R2: In the head, each operand kind is REG (2'd0), IMM (2'd1), MEM (2'd2) or reserved (2'd3). Any kind other than REG counts as non-register. The head qualifies only if at least one of its two operands is REG.
- R3: The jump qualifies only if its 4-bit condition code is in 2..7, the codes that read only CF and/or ZF. The codes 0, 1 and 8..15 never fuse.
- R4: While long_mode_i is 1, fuse_o is all zero and tail_hold_o is 0.
- R5: A pair fuses only when both entries have their valid bit set.
- R6: fuse_o[i] set means entry i fuses with entry i+1. Pairs are taken from oldest to newest, an entry that completes a pair never starts another, and several separate pairs may fuse at once. The highest entry is never marked.
- R7: mop_count_o equals the number of valid entries minus the number of set fuse bits.
- R8: When the highest-indexed valid entry satisfies the head conditions of R1, R2 and R4, tail_hold_o is 1 for exactly WAIT_MAX consecutive cycles, starting in the cycle the candidate appears. It then stays 0 for as long as that candidate remains.
- R9: tail_hold_o drops in the same cycle the tail stops being a candidate, for example when its jump arrives. A candidate that appears after at least one cycle without one gets a full WAIT_MAX-cycle hold.
- R10: After reset, with an empty queue, fuse_o, tail_hold_o and mop_count_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ent_valid_i | input | DEPTH | Valid bit per queue entry, bit 0 oldest |
| ent_class_i | input | 2*DEPTH | Class field per entry, entry i at bits [2i+1:2i] |
| ent_src_a_i | input | 2*DEPTH | First operand kind per entry |
| ent_src_b_i | input | 2*DEPTH | Second operand kind per entry |
| ent_cc_i | input | 4*DEPTH | Jump condition code per entry, entry i at bits [4i+3:4i] |
| long_mode_i | input | 1 | 1 when the machine runs in 64-bit mode |
| fuse_o | output | DEPTH | Entry i fuses with entry i+1 |
| tail_hold_o | output | 1 | Keep the newest entry back while its jump may still arrive |
| mop_count_o | output | $clog2(DEPTH+1) | Macro-operations in the window after fusion |

## Verification
The assertions check the following on every cycle:
- Each fuse bit sits on a valid pair whose second entry is a jump.
- No two neighbouring fuse bits are set, and the last entry is never marked.
- Neither fuse bits nor the hold appear in 64-bit mode.
- The hold never lasts longer than WAIT_MAX cycles.
- The slot count never exceeds the valid count.

Some properties can only be shown by the bench's directed scenarios:
- The exact qualifying sets of operand kinds and condition codes.
- The fuse pattern of a window holding several pairs.
- The precise hold length.
- The re-arming of the hold after a jump arrives.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

    typedef enum logic [1:0] {
        OPC_OTHER = 2'd0,
        OPC_TEST  = 2'd1,
        OPC_CMP   = 2'd2,
        OPC_JCC   = 2'd3
    } opc_e;

    typedef enum logic [1:0] {
        SRC_REG = 2'd0,
        SRC_IMM = 2'd1,
        SRC_MEM = 2'd2,
        SRC_RSV = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_SCAN    = 2'd0,
        ST_WAIT    = 2'd1,
        ST_RELEASE = 2'd2
    } wait_st_e;

    // condition codes that read only CF, only ZF, or both
    localparam logic [3:0] CC_FLAG_LO = 4'd2;
    localparam logic [3:0] CC_FLAG_HI = 4'd7;

endpackage

// File: rtl/cmpbr_slot_decode.sv
module cmpbr_slot_decode
    import cbf_pkg::*;
(
    input  logic       valid_i,
    input  logic [1:0] cls_i,
    input  logic [1:0] src_a_i,
    input  logic [1:0] src_b_i,
    input  logic [3:0] cc_i,
    output logic       head_ok_o,
    output logic       jump_ok_o
);
    opc_e cls;
    src_e src_a;
    src_e src_b;
    logic is_compare;
    logic both_wide;
    logic cc_flag_only;

    assign cls   = opc_e'(cls_i);
    assign src_a = src_e'(src_a_i);
    assign src_b = src_e'(src_b_i);

    always_comb begin
        is_compare   = (cls == OPC_TEST) || (cls == OPC_CMP);
        both_wide    = (src_a != SRC_REG) && (src_b != SRC_REG);
        cc_flag_only = (cc_i >= CC_FLAG_LO) && (cc_i <= CC_FLAG_HI);
        head_ok_o    = valid_i && is_compare && !both_wide;
        jump_ok_o    = valid_i && (cls == OPC_JCC) && cc_flag_only;
    end

endmodule

// File: rtl/cmpbr_pair_scan.sv
module cmpbr_pair_scan #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] valid_i,
    input  logic [DEPTH-1:0] head_ok_i,
    input  logic [DEPTH-1:0] jump_ok_i,
    input  logic             long_mode_i,
    output logic [DEPTH-1:0] fuse_o,
    output logic [CNT_W-1:0] mop_count_o,
    output logic             tail_cand_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             consumed;
    logic [CNT_W-1:0] n_valid;
    logic [CNT_W-1:0] n_fused;
    logic [IDX_W-1:0] tail_idx;
    logic             any_valid;
    logic             unused_first_jump;

    // entry 0 can only ever be a head
    assign unused_first_jump = jump_ok_i[0];

    // oldest-first scan; an entry that closes a pair cannot open one
    always_comb begin
        fuse_o   = '0;
        consumed = 1'b0;
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (!long_mode_i && !consumed && head_ok_i[i] && jump_ok_i[i+1]) begin
                fuse_o[i] = 1'b1;
            end
            consumed = fuse_o[i];
        end
    end

    always_comb begin
        n_valid = '0;
        n_fused = '0;
        for (int i = 0; i < DEPTH; i++) begin
            n_valid = n_valid + CNT_W'(valid_i[i]);
            n_fused = n_fused + CNT_W'(fuse_o[i]);
        end
        mop_count_o = n_valid - n_fused;
    end

    always_comb begin
        tail_idx  = '0;
        any_valid = |valid_i;
        for (int i = 0; i < DEPTH; i++) begin
            if (valid_i[i]) begin
                tail_idx = IDX_W'(i);
            end
        end
        tail_cand_o = any_valid && !long_mode_i && head_ok_i[tail_idx];
    end

endmodule

// File: rtl/cmpbr_tail_wait.sv
module cmpbr_tail_wait
    import cbf_pkg::*;
#(
    parameter int WAIT_MAX = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cand_i,
    output logic hold_o
);
    localparam int CW = $clog2(WAIT_MAX + 1);

    wait_st_e        state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_SCAN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_SCAN: begin
                if (cand_i) begin
                    state_d = ST_WAIT;
                    cnt_d   = CW'(1);
                end
            end
            ST_WAIT: begin
                if (!cand_i) begin
                    state_d = ST_SCAN;
                    cnt_d   = '0;
                end else if (cnt_q == CW'(WAIT_MAX - 1)) begin
                    state_d = ST_RELEASE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_RELEASE: begin
                if (!cand_i) begin
                    state_d = ST_SCAN;
                end
            end
            default: begin
                state_d = ST_SCAN;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_SCAN, ST_WAIT: hold_o = cand_i;
            ST_RELEASE:       hold_o = 1'b0;
            default:          hold_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmpbr_fuse.sv
module cmpbr_fuse #(
    parameter int DEPTH    = 8,
    parameter int WAIT_MAX = 4,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [DEPTH-1:0]   ent_valid_i,
    input  logic [2*DEPTH-1:0] ent_class_i,
    input  logic [2*DEPTH-1:0] ent_src_a_i,
    input  logic [2*DEPTH-1:0] ent_src_b_i,
    input  logic [4*DEPTH-1:0] ent_cc_i,
    input  logic               long_mode_i,
    output logic [DEPTH-1:0]   fuse_o,
    output logic               tail_hold_o,
    output logic [CNT_W-1:0]   mop_count_o
);
    logic [DEPTH-1:0] head_ok;
    logic [DEPTH-1:0] jump_ok;
    logic             tail_cand;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        cmpbr_slot_decode u_dec (
            .valid_i   (ent_valid_i[g]),
            .cls_i     (ent_class_i[2*g +: 2]),
            .src_a_i   (ent_src_a_i[2*g +: 2]),
            .src_b_i   (ent_src_b_i[2*g +: 2]),
            .cc_i      (ent_cc_i[4*g +: 4]),
            .head_ok_o (head_ok[g]),
            .jump_ok_o (jump_ok[g])
        );
    end

    cmpbr_pair_scan #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_scan (
        .valid_i     (ent_valid_i),
        .head_ok_i   (head_ok),
        .jump_ok_i   (jump_ok),
        .long_mode_i (long_mode_i),
        .fuse_o      (fuse_o),
        .mop_count_o (mop_count_o),
        .tail_cand_o (tail_cand)
    );

    cmpbr_tail_wait #(
        .WAIT_MAX (WAIT_MAX)
    ) u_wait (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cand_i (tail_cand),
        .hold_o (tail_hold_o)
    );

endmodule

// File: rtl/cmpbr_fuse_chk.sv
module cmpbr_fuse_chk #(
    parameter int DEPTH    = 8,
    parameter int WAIT_MAX = 4,
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [DEPTH-1:0]   ent_valid_i,
    input logic [2*DEPTH-1:0] ent_class_i,
    input logic               long_mode_i,
    input logic [DEPTH-1:0]   fuse_o,
    input logic               tail_hold_o,
    input logic [CNT_W-1:0]   mop_count_o
);
    localparam int RW = $clog2(WAIT_MAX + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else if (tail_hold_o) begin
            if (run_q < RW'(WAIT_MAX)) run_q <= run_q + RW'(1);
        end else begin
            run_q <= '0;
        end
    end

    for (genvar g = 0; g < DEPTH - 1; g++) begin : g_pair
        a_r5_both_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
            fuse_o[g] |-> (ent_valid_i[g] && ent_valid_i[g+1]));
        a_r1_jump_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
            fuse_o[g] |-> (ent_class_i[2*(g+1) +: 2] == 2'd3));
        a_r6_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
            fuse_o[g] |-> !fuse_o[g+1]);
    end

    a_r6_last_unmarked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fuse_o[DEPTH-1]);

    a_r4_mode_blocks_fuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        long_mode_i |-> (fuse_o == '0));

    a_r4_mode_blocks_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        long_mode_i |-> !tail_hold_o);

    a_r8_hold_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tail_hold_o |-> (run_q < RW'(WAIT_MAX)));

    a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(mop_count_o) <= $countones(ent_valid_i));

endmodule

bind cmpbr_fuse cmpbr_fuse_chk #(
    .DEPTH    (DEPTH),
    .WAIT_MAX (WAIT_MAX),
    .CNT_W    (CNT_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ent_valid_i (ent_valid_i),
    .ent_class_i (ent_class_i),
    .long_mode_i (long_mode_i),
    .fuse_o      (fuse_o),
    .tail_hold_o (tail_hold_o),
    .mop_count_o (mop_count_o)
);

// File: tb/cmpbr_fuse_tb_top.sv
module cmpbr_fuse_tb_top;
    localparam int DEPTH = 8;
    localparam int WMAX  = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    localparam logic [1:0] C_OTH = 2'd0, C_TST = 2'd1, C_CMP = 2'd2, C_JCC = 2'd3;
    localparam logic [1:0] K_REG = 2'd0, K_IMM = 2'd1, K_MEM = 2'd2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [DEPTH-1:0]   valid = '0;
    logic [2*DEPTH-1:0] cls = '0;
    logic [2*DEPTH-1:0] sa = '0;
    logic [2*DEPTH-1:0] sb = '0;
    logic [4*DEPTH-1:0] cc = '0;
    logic               lm = 1'b0;
    logic [DEPTH-1:0]   fuse;
    logic               hold;
    logic [CW-1:0]      mops;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    cmpbr_fuse #(.DEPTH(DEPTH), .WAIT_MAX(WMAX)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ent_valid_i(valid), .ent_class_i(cls),
        .ent_src_a_i(sa), .ent_src_b_i(sb), .ent_cc_i(cc), .long_mode_i(lm),
        .fuse_o(fuse), .tail_hold_o(hold), .mop_count_o(mops)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input int i, input logic [1:0] c, input logic [1:0] a,
                       input logic [1:0] b, input logic [3:0] code);
        valid[i]     = 1'b1;
        cls[2*i +: 2] = c;
        sa[2*i +: 2]  = a;
        sb[2*i +: 2]  = b;
        cc[4*i +: 4]  = code;
    endtask

    task automatic clear_q();
        valid = '0; cls = '0; sa = '0; sb = '0; cc = '0; lm = 1'b0;
    endtask

    // empty the queue and let the wait machine return to scan
    task automatic settle();
        @(negedge clk); clear_q();
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); #2;
        check("R10 fuse", int'(fuse), 0);
        check("R10 hold", int'(hold), 0);
        check("R10 mops", int'(mops), 0);
    endtask

    task automatic t_basic();
        @(negedge clk); clear_q();
        put(0, C_CMP, K_REG, K_REG, 4'd4);
        put(1, C_JCC, K_REG, K_REG, 4'd4);
        #2;
        check("R1 cmp+je fuse", int'(fuse), 1);
        check("R7 mops pair", int'(mops), 1);
        put(2, C_OTH, K_REG, K_REG, 4'd0);
        put(3, C_OTH, K_REG, K_REG, 4'd0);
        #2;
        check("R1 pair then others", int'(fuse), 1);
        check("R7 mops 4 valid", int'(mops), 3);
        cls[1:0] = C_OTH; #2;
        check("R1 other head", int'(fuse), 0);
        cls[1:0] = C_TST; cls[3:2] = C_OTH; #2;
        check("R1 test then other", int'(fuse), 0);
        cls[3:2] = C_JCC; #2;
        check("R1 test+jcc fuse", int'(fuse), 1);
    endtask

    task automatic t_operands();
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                @(negedge clk); clear_q();
                put(0, C_TST, 2'(a), 2'(b), 4'd0);
                put(1, C_JCC, K_REG, K_REG, 4'd5);
                #2;
                check($sformatf("R2 kinds %0d,%0d", a, b), int'(fuse),
                      (a == 0 || b == 0) ? 1 : 0);
            end
        end
    endtask

    task automatic t_codes();
        for (int c = 0; c < 16; c++) begin
            @(negedge clk); clear_q();
            put(0, C_CMP, K_MEM, K_REG, 4'd0);
            put(1, C_JCC, K_REG, K_REG, 4'(c));
            #2;
            check($sformatf("R3 cc %0d", c), int'(fuse), (c >= 2 && c <= 7) ? 1 : 0);
        end
    endtask

    task automatic t_mode_valid();
        @(negedge clk); clear_q();
        put(0, C_CMP, K_REG, K_IMM, 4'd0);
        put(1, C_JCC, K_REG, K_REG, 4'd7);
        put(2, C_OTH, K_REG, K_REG, 4'd0);
        #2;
        check("R4 mode off fuses", int'(fuse), 1);
        lm = 1'b1; #2;
        check("R4 long mode fuse", int'(fuse), 0);
        check("R4 long mode mops", int'(mops), 3);
        lm = 1'b0; valid[1] = 1'b0; #2;
        check("R5 invalid jump", int'(fuse), 0);
        valid[1] = 1'b1; valid[0] = 1'b0; #2;
        check("R5 invalid head", int'(fuse), 0);
        settle();
    endtask

    task automatic t_multi();
        @(negedge clk); clear_q();
        put(0, C_CMP, K_REG, K_REG, 4'd4);
        put(1, C_JCC, K_REG, K_REG, 4'd4);
        put(2, C_TST, K_MEM, K_REG, 4'd0);
        put(3, C_JCC, K_REG, K_REG, 4'd5);
        put(4, C_OTH, K_REG, K_REG, 4'd0);
        put(5, C_CMP, K_REG, K_IMM, 4'd0);
        put(6, C_JCC, K_REG, K_REG, 4'd7);
        put(7, C_OTH, K_REG, K_REG, 4'd0);
        #2;
        check("R6 three pairs", int'(fuse), 8'b0010_0101);
        check("R7 mops three pairs", int'(mops), 5);
        cls[15:14] = C_CMP; #2;
        check("R6 full tail head", int'(fuse), 8'b0010_0101);
        settle();
    endtask

    task automatic t_hold_timeout();
        @(negedge clk); clear_q();
        put(0, C_OTH, K_REG, K_REG, 4'd0);
        put(1, C_OTH, K_REG, K_REG, 4'd0);
        put(2, C_CMP, K_REG, K_MEM, 4'd0);
        #2;
        check("R8 hold cycle 0", int'(hold), 1);
        for (int k = 1; k <= WMAX; k++) begin
            @(negedge clk); #2;
            check($sformatf("R8 hold cycle %0d", k), int'(hold), (k < WMAX) ? 1 : 0);
        end
        @(negedge clk); #2;
        check("R8 stays released", int'(hold), 0);
        put(3, C_JCC, K_REG, K_REG, 4'd6); #2;
        check("R8 late jump fuses", int'(fuse), 8'b0000_0100);
        settle();
    endtask

    task automatic t_hold_resolve();
        @(negedge clk); clear_q();
        put(0, C_OTH, K_REG, K_REG, 4'd0);
        put(1, C_TST, K_REG, K_REG, 4'd0);
        #2;
        check("R9 hold starts", int'(hold), 1);
        @(negedge clk); #2;
        check("R9 hold still", int'(hold), 1);
        put(2, C_JCC, K_REG, K_REG, 4'd2); #2;
        check("R9 jump drops hold", int'(hold), 0);
        check("R9 jump fuses", int'(fuse), 8'b0000_0010);
        @(negedge clk);
        valid[2] = 1'b0; #2;
        check("R9 rearm cycle 0", int'(hold), 1);
        for (int k = 1; k <= WMAX; k++) begin
            @(negedge clk); #2;
            check($sformatf("R9 rearm cycle %0d", k), int'(hold), (k < WMAX) ? 1 : 0);
        end
        settle();
        @(negedge clk);
        put(0, C_CMP, K_REG, K_REG, 4'd0); lm = 1'b1; #2;
        check("R4 no hold in long mode", int'(hold), 0);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_operands();
        t_codes();
        t_mode_valid();
        t_multi();
        t_hold_timeout();
        t_hold_resolve();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule